// File: doc/BRIEF.md
# Indirect shared-register access bridge

This bridge lets a host on a 32-bit register bus reach a small shared register space that stays powered when the main logic is down. The host never addresses the shared space directly. It sees two words in its own register window: a control word and a data word. Writing the control word names a target offset and an operation. A read operation fetches the target into the data word. A write operation stores the value already staged in the data word at the target.

The shared space holds 1024 words and is always clocked. It is reached through an arbiter that another agent can claim with `shr_hold_i`. While a launched access waits for the grant, the bridge reports busy in the control word. It then refuses new control writes and new data writes. Only one access is outstanding at a time. In this project the shared words are a local array.

Top module: `shr_bridge`

## Requirements
- R1: After reset, a host read of either the control word or the data word returns 0. `rvalid_o` is low until the first host read.
- R2: The control word sits at host offset 0xEC and the data word at 0xF4. A host read of any other offset returns 0, and a host write to it changes nothing. The control word reads back as follows: bit 31 is busy, bits 29:28 are the last accepted opcode, bits 15:0 are the last accepted offset, and all other bits are 0.
- R3: A control write with opcode 2 in bits 29:28 and an offset in bits 15:0 loads the data word with the shared word at that offset.
- R4: A control write with opcode 3 stores the current data word at the offset. It does not change the data word.
- R5: The shared space covers offsets 0x000 to 0x3FF. If any of offset bits 15:10 is set, a read loads 0 into the data word and a write leaves every shared word unchanged.
- R6: Opcodes 0 and 1 are no-ops. They change neither the data word nor any shared word, but they do update the offset and opcode fields of the control word.
- R7: From the control write that launches an access until the arbiter grants it, control bit 31 reads 1. A grant cannot occur while `shr_hold_i` is high. Bit 31 reads 0 from the cycle after the grant.
- R8: A host read of the data word while busy returns the value the data word held before the access was launched.
- R9: While busy, host writes to the control word and to the data word are ignored.
- R10: A host read delivers its data on `rdata_o` with `rvalid_o` high in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, one cycle per access |
| we_i | input | 1 | 1 = host write, 0 = host read |
| addr_i | input | 8 | Byte offset in the host window |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data, registered |
| rvalid_o | output | 1 | High in the cycle after a host read request |
| shr_hold_i | input | 1 | Another agent owns the shared space; blocks the grant |

## Verification
The hardest state to reach from the ports is a long busy window in which stray host traffic arrives. The bench drives it by raising `shr_hold_i` before launching a read and keeping it high for more than twenty cycles. During that window it polls the control word, reads the stale data word, and sends a competing control write and a data write. It then drops the hold and confirms three things: the original target was fetched, the competing write never reached the shared space, and the competing data never reached the data word.

// File: rtl/shr_br_pkg.sv
package shr_br_pkg;
  typedef enum logic [1:0] {
    OP_NOP0 = 2'd0,
    OP_NOP1 = 2'd1,
    OP_RD   = 2'd2,
    OP_WR   = 2'd3
  } shr_op_e;

  localparam int OP_LSB   = 28;
  localparam int BUSY_BIT = 31;
endpackage

// File: rtl/shr_host_regs.sv
module shr_host_regs
  import shr_br_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int OFF_W  = 16,
  parameter int SHR_AW = 10,
  parameter logic [AW-1:0] CTRL_OFS = 8'hEC,
  parameter logic [AW-1:0] DATA_OFS = 8'hF4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic [DW-1:0]    rd_data_i,
  output logic             launch_o,
  output shr_op_e          op_o,
  output logic [OFF_W-1:0] off_o,
  output logic [DW-1:0]    data_o
);
  logic             ctrl_hit, data_hit, ctrl_wr, data_wr;
  logic [OFF_W-1:0] off_q;
  shr_op_e          op_q;
  logic [DW-1:0]    data_q, ctrl_view, rd_mux;

  assign ctrl_hit = req_i && (addr_i == CTRL_OFS);
  assign data_hit = req_i && (addr_i == DATA_OFS);
  assign ctrl_wr  = ctrl_hit && we_i && !busy_i;
  assign data_wr  = data_hit && we_i && !busy_i;
  assign launch_o = ctrl_wr && wdata_i[OP_LSB+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      op_q  <= OP_NOP0;
    end else if (ctrl_wr) begin
      off_q <= wdata_i[OFF_W-1:0];
      op_q  <= shr_op_e'(wdata_i[OP_LSB +: 2]);
    end
  end

  // completion of a read wins over host writes (host writes are blocked while busy anyway)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     data_q <= '0;
    else if (done_i && op_q == OP_RD) data_q <= rd_data_i;
    else if (data_wr)                data_q <= wdata_i;
  end

  always_comb begin
    ctrl_view                 = '0;
    ctrl_view[OFF_W-1:0]      = off_q;
    ctrl_view[OP_LSB +: 2]    = op_q;
    ctrl_view[BUSY_BIT]       = busy_i;
    if (addr_i == CTRL_OFS)      rd_mux = ctrl_view;
    else if (addr_i == DATA_OFS) rd_mux = data_q;
    else                         rd_mux = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rd_mux;
    end
  end

  assign op_o   = op_q;
  assign off_o  = off_q;
  assign data_o = data_q;

  a_r9_ctrl_ignored_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(off_q) && $stable(op_q)));
  a_r8_data_frozen_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> $stable(data_q));
  a_r6_nop_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_hit && we_i && !busy_i && !wdata_i[OP_LSB+1]) |=> $stable(data_q));
  a_r5_oor_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && op_q == OP_RD && (|off_q[OFF_W-1:SHR_AW])) |=> (data_q == '0));
  a_r10_rvalid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
endmodule

// File: rtl/shr_cmd_ctl.sv
module shr_cmd_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic gnt_i,
  output logic busy_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       busy_q <= 1'b0;
    else if (launch_i) busy_q <= 1'b1;
    else if (gnt_i)    busy_q <= 1'b0;
  end

  assign busy_o = busy_q;

  a_r7_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !gnt_i) |=> busy_q);
  a_r7_busy_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && gnt_i) |=> !busy_q);
endmodule

// File: rtl/shr_arbiter.sv
module shr_arbiter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic hold_i,
  output logic gnt_o
);
  // the other agent owns the space for as long as it holds
  assign gnt_o = req_i && !hold_i;

  a_r7_no_gnt_on_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !gnt_o);
endmodule

// File: rtl/shr_store.sv
module shr_store
  import shr_br_pkg::*;
#(
  parameter int DW     = 32,
  parameter int OFF_W  = 16,
  parameter int SHR_AW = 10,
  localparam int DEPTH = 1 << SHR_AW
) (
  input  logic             clk_i,
  input  logic             fire_i,
  input  shr_op_e          op_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rd_data_o
);
  logic [DW-1:0] mem [DEPTH];
  logic          in_range;

  assign in_range = ~|off_i[OFF_W-1:SHR_AW];

  always_ff @(posedge clk_i) begin
    if (fire_i && op_i == OP_WR && in_range) mem[off_i[SHR_AW-1:0]] <= wdata_i;
  end

  assign rd_data_o = in_range ? mem[off_i[SHR_AW-1:0]] : '0;
endmodule

// File: rtl/shr_bridge.sv
module shr_bridge
  import shr_br_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int OFF_W  = 16,
  parameter int SHR_AW = 10,
  parameter logic [AW-1:0] CTRL_OFS = 8'hEC,
  parameter logic [AW-1:0] DATA_OFS = 8'hF4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  input  logic          shr_hold_i
);
  logic             busy, gnt, launch;
  shr_op_e          op;
  logic [OFF_W-1:0] off;
  logic [DW-1:0]    data, rd_data;

  shr_host_regs #(
    .AW(AW), .DW(DW), .OFF_W(OFF_W), .SHR_AW(SHR_AW),
    .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
  ) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .rvalid_o,
    .busy_i(busy), .done_i(gnt), .rd_data_i(rd_data),
    .launch_o(launch), .op_o(op), .off_o(off), .data_o(data)
  );

  shr_cmd_ctl u_ctl (
    .clk_i, .rst_ni, .launch_i(launch), .gnt_i(gnt), .busy_o(busy)
  );

  shr_arbiter u_arb (
    .clk_i, .rst_ni, .req_i(busy), .hold_i(shr_hold_i), .gnt_o(gnt)
  );

  shr_store #(.DW(DW), .OFF_W(OFF_W), .SHR_AW(SHR_AW)) u_store (
    .clk_i, .fire_i(gnt), .op_i(op), .off_i(off), .wdata_i(data),
    .rd_data_o(rd_data)
  );
endmodule

// File: tb/sim_shr_bridge.sv
module sim_shr_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, hold = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rvalid;
  int          n_vec = 0, n_bad = 0;

  localparam logic [7:0] A_CTRL = 8'hEC;
  localparam logic [7:0] A_DATA = 8'hF4;

  always #10 clk = ~clk;

  shr_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .shr_hold_i(hold)
  );

  function automatic logic [31:0] pat(input int i);
    logic [31:0] v;
    v = 32'(i) * 32'h9E3779B1;
    return v ^ 32'h5A5A0000;
  endfunction

  function automatic logic [31:0] ctrl_word(input logic [1:0] op, input logic [15:0] off);
    return {2'b00, op, 12'h000, off};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    d = rdata;
    chk("R10 rvalid after read", {31'b0, rvalid}, 32'd1);
  endtask

  task automatic wait_idle;
    logic [31:0] c;
    c = 32'h8000_0000;
    for (int k = 0; k < 50 && c[31]; k++) host_rd(A_CTRL, c);
    chk("R7 busy clears after grant", {31'b0, c[31]}, 32'd0);
  endtask

  task automatic shr_read(input logic [15:0] off, output logic [31:0] d);
    host_wr(A_CTRL, ctrl_word(2'd2, off));
    wait_idle();
    host_rd(A_DATA, d);
  endtask

  task automatic shr_write(input logic [15:0] off, input logic [31:0] d);
    host_wr(A_DATA, d);
    host_wr(A_CTRL, ctrl_word(2'd3, off));
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rvalid low after reset", {31'b0, rvalid}, 32'd0);
    host_rd(A_CTRL, d);  chk("R1 control after reset", d, 32'd0);
    host_rd(A_DATA, d);  chk("R1 data after reset", d, 32'd0);

    // R2 window decode
    host_wr(A_DATA, 32'h1234_5678);
    host_rd(A_DATA, d);  chk("R2 data readback", d, 32'h1234_5678);
    host_wr(8'h10, 32'hFFFF_FFFF);
    host_rd(8'h10, d);   chk("R2 unmapped reads zero", d, 32'd0);
    host_rd(A_DATA, d);  chk("R2 unmapped write no effect", d, 32'h1234_5678);

    // R4 exhaustive write, R3 exhaustive read
    for (int i = 0; i < 1024; i++) shr_write(16'(i), pat(i));
    host_rd(A_CTRL, d);  chk("R2 control fields", d, ctrl_word(2'd3, 16'h03FF));
    host_rd(A_DATA, d);  chk("R4 data word unchanged by write", d, pat(1023));
    for (int i = 0; i < 1024; i++) begin
      shr_read(16'(i), d);
      chk("R3 read back shared word", d, pat(i));
    end

    // R5 out-of-range offsets
    for (int k = 0; k < 8; k++) begin
      shr_write(16'h0400 + 16'(k), ~pat(k));
      shr_write(16'hFC00 + 16'(k * 3), ~pat(k * 3));
    end
    for (int k = 0; k < 8; k++) begin
      shr_read(16'(k), d);            chk("R5 discarded write alias", d, pat(k));
      shr_read(16'(k * 3), d);        chk("R5 discarded write alias", d, pat(k * 3));
      shr_read(16'h8000 | 16'(k), d); chk("R5 out-of-range read zero", d, 32'd0);
    end

    // R6 no-op opcodes
    host_wr(A_DATA, 32'hDEAD_BEEF);
    host_wr(A_CTRL, ctrl_word(2'd0, 16'd7));
    wait_idle();
    host_rd(A_DATA, d);  chk("R6 op0 keeps data", d, 32'hDEAD_BEEF);
    host_rd(A_CTRL, d);  chk("R6 op0 updates control fields", d, ctrl_word(2'd0, 16'd7));
    host_wr(A_CTRL, ctrl_word(2'd1, 16'd9));
    wait_idle();
    host_rd(A_DATA, d);  chk("R6 op1 keeps data", d, 32'hDEAD_BEEF);
    shr_read(16'd9, d);  chk("R6 op1 no store", d, pat(9));
    shr_read(16'd7, d);  chk("R6 op0 no store", d, pat(7));

    // R7 R8 R9 held grant
    shr_read(16'd3, d);
    hold = 1'b1;
    host_wr(A_CTRL, ctrl_word(2'd2, 16'd100));
    host_rd(A_CTRL, d);  chk("R7 busy while held", {31'b0, d[31]}, 32'd1);
    host_rd(A_DATA, d);  chk("R8 stale data while busy", d, pat(3));
    host_wr(A_CTRL, ctrl_word(2'd3, 16'd200));
    host_wr(A_DATA, 32'h0BAD_0BAD);
    repeat (20) @(negedge clk);
    host_rd(A_CTRL, d);  chk("R7 busy after long hold", d, 32'h8000_0000 | ctrl_word(2'd2, 16'd100));
    host_rd(A_DATA, d);  chk("R9 data write ignored while busy", d, pat(3));
    hold = 1'b0;
    wait_idle();
    host_rd(A_DATA, d);  chk("R3 held read completes", d, pat(100));
    shr_read(16'd200, d); chk("R9 control write ignored while busy", d, pat(200));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule